// File: doc/BRIEF.md
# Fixed-Rate Waveform DAC Frame Sequencer

This block feeds a multi-channel serial DAC from a free-running frame timer. At the start of every frame it takes four 16-bit waveform samples and sends them to the DAC in one chip-select window: an address byte, then the four samples. It then releases chip-select and pulses an active-low load line, so that all four waveform outputs change on the same instant.

In the time left in the frame it can make one single-channel write to one of four auxiliary channels. Auxiliary requests can arrive at any time and wait in a one-entry holding slot. A newer request replaces an older one that has not been sent yet.

The waveform traffic always has priority. Whether an auxiliary write fits after the load pulse is settled from the parameters alone, so an auxiliary write can never push the next frame's burst or strobe later. All delays are whole system-clock cycles, rounded up from nanosecond minimums. The default settings are a 100 MHz system clock, a 50 MHz serial clock and a 250-cycle (2.5 us) frame.

Top module: `dacseq_top`

## Requirements
- R1: `frame_start` is high for exactly one cycle every FRAME_CYC cycles, and the first pulse is in the first cycle after reset is released. The waveform samples present in that cycle are the ones sent in the frame, and later changes to `wave_in` do not affect that frame.
- R2: In the cycle after `frame_start`, `dac_cs_n` goes low and stays low for exactly 72 serial-clock periods. The 72 bits are sent MSB first, in this order: WAVE_ADDR (8 bits), then channel 0 (`wave_in[15:0]`), channel 1 (`[31:16]`), channel 2 (`[47:32]`) and channel 3 (`[63:48]`).
- R3: `dac_sclk` is low whenever `dac_cs_n` is high. Each bit spends SCLK_HALF_CYC cycles with the clock low and then SCLK_HALF_CYC cycles with it high. `dac_mosi` changes only when the clock goes low, so it is stable on every rising edge.
- R4: After the burst, `dac_cs_n` goes high. `dac_load_n` goes low after ceil(PRE_GAP_NS) worth of cycles and stays low for ceil(STROBE_NS) worth of cycles, at least one cycle each. It is low only while `dac_cs_n` is high.
- R5: After `dac_load_n` returns high, `dac_cs_n` stays high for at least ceil(POST_GAP_NS) worth of cycles before it goes low again.
- R6: An auxiliary write is its own chip-select window of 24 bits, sent MSB first: the address byte UTIL_ADDR_BASE + `util_ch`, then the 16-bit value. It begins in the first cycle after the post-strobe gap.
- R7: A request (`util_req` high for one cycle) is held in a one-entry slot, and a newer request overwrites one that is still waiting. At most one auxiliary write is made per frame, and starting it empties the slot. A request made in the same cycle as the launch decision stays in the slot for the next frame.
- R8: With no request waiting, no second chip-select window appears in the frame. The waveform burst and the load strobe keep the same timing whatever requests are made.
- R9: All chip-select activity of a frame, auxiliary write included, ends before the next frame starts. With the defaults this takes 198 cycles, within 125 serial-clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_in | input | 64 | Four waveform samples; channel c at bits [16c+15:16c] |
| util_req | input | 1 | One-cycle auxiliary write request |
| util_ch | input | 2 | Auxiliary channel index 0..3 |
| util_val | input | 16 | Auxiliary write value |
| frame_start | output | 1 | One-cycle pulse when the samples are taken |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_mosi | output | 1 | Serial data to the DAC |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_load_n | output | 1 | Active-low synchronous load strobe |

## Verification
Any fault in the sequencer's counters or state moves an edge of `dac_cs_n`, `dac_load_n` or `dac_sclk`. A shifted edge differs from the reference on the cycle it appears, which is no later than the first frame that reaches the faulty state. A corrupt shift register or a wrong word order gives a wrong `dac_mosi` bit within one serial-clock period of the fault. A fault in the holding slot shows up as an auxiliary window that is missing, extra or carries the wrong value. That becomes visible at the next launch point after the request, so within one or two frames.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    localparam int STREAM_BITS = 72;
    localparam int UTIL_BITS   = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STREAM,
        ST_GAP_PRE,
        ST_STROBE,
        ST_GAP_POST,
        ST_UTIL
    } seq_state_e;

    // Convert a nanosecond minimum into whole clock cycles, rounding up, never below one.
    function automatic int ns_to_cyc(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/dacseq_frame_timer.sv
module dacseq_frame_timer #(
    parameter int FRAME_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(FRAME_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == CW'(FRAME_CYC - 1)) tmr_d.cnt = '0;
        else                                 tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick = (tmr_q.cnt == '0);
endmodule

// File: rtl/dacseq_util_slot.sv
module dacseq_util_slot (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [1:0]  req_ch,
    input  logic [15:0] req_val,
    input  logic        take,
    output logic        pend_v,
    output logic [1:0]  pend_ch,
    output logic [15:0] pend_val
);
    typedef struct packed {
        logic        v;
        logic [1:0]  ch;
        logic [15:0] val;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (req) begin
            slot_d.v   = 1'b1;
            slot_d.ch  = req_ch;
            slot_d.val = req_val;
        end else if (take) begin
            slot_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign pend_v   = slot_q.v;
    assign pend_ch  = slot_q.ch;
    assign pend_val = slot_q.val;
endmodule

// File: rtl/dacseq_serializer.sv
module dacseq_serializer #(
    parameter int MAX_BITS = 72,
    parameter int HALF_CYC = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [$clog2(MAX_BITS+1)-1:0]  start_bits,
    input  logic [MAX_BITS-1:0]            start_word,
    output logic                           sclk,
    output logic                           mosi,
    output logic                           finishing
);
    localparam int NW = $clog2(MAX_BITS + 1);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef struct packed {
        logic                active;
        logic                phase;   // 0: clock low half, 1: clock high half
        logic [HW-1:0]       hcnt;
        logic [NW-1:0]       remaining;
        logic [MAX_BITS-1:0] shreg;
        logic                sclk;
        logic                mosi;
    } ser_t;

    ser_t ser_d, ser_q;

    always_comb begin
        ser_d     = ser_q;
        finishing = 1'b0;
        if (start) begin
            ser_d.active    = 1'b1;
            ser_d.phase     = 1'b0;
            ser_d.hcnt      = '0;
            ser_d.remaining = start_bits - 1'b1;
            ser_d.mosi      = start_word[MAX_BITS-1];
            ser_d.shreg     = start_word << 1;
            ser_d.sclk      = 1'b0;
        end else if (ser_q.active) begin
            if (ser_q.hcnt == HW'(HALF_CYC - 1)) begin
                ser_d.hcnt = '0;
                if (!ser_q.phase) begin
                    ser_d.phase = 1'b1;
                    ser_d.sclk  = 1'b1;
                end else if (ser_q.remaining == '0) begin
                    ser_d.active = 1'b0;
                    ser_d.sclk   = 1'b0;
                    ser_d.mosi   = 1'b0;
                    finishing    = 1'b1;
                end else begin
                    ser_d.phase     = 1'b0;
                    ser_d.sclk      = 1'b0;
                    ser_d.mosi      = ser_q.shreg[MAX_BITS-1];
                    ser_d.shreg     = ser_q.shreg << 1;
                    ser_d.remaining = ser_q.remaining - 1'b1;
                end
            end else begin
                ser_d.hcnt = ser_q.hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '0;
        else        ser_q <= ser_d;
    end

    assign sclk = ser_q.sclk;
    assign mosi = ser_q.mosi;
endmodule

// File: rtl/dacseq_top.sv
module dacseq_top
    import dacseq_pkg::*;
#(
    parameter int          FRAME_CYC      = 250,
    parameter int          SCLK_HALF_CYC  = 1,
    parameter int          CLK_PERIOD_PS  = 10000,
    parameter int          PRE_GAP_NS     = 20,
    parameter int          STROBE_NS      = 20,
    parameter int          POST_GAP_NS    = 15,
    parameter logic [7:0]  WAVE_ADDR      = 8'h14,
    parameter logic [7:0]  UTIL_ADDR_BASE = 8'h18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] wave_in,
    input  logic        util_req,
    input  logic [1:0]  util_ch,
    input  logic [15:0] util_val,
    output logic        frame_start,
    output logic        dac_sclk,
    output logic        dac_mosi,
    output logic        dac_cs_n,
    output logic        dac_load_n
);
    localparam int PRE_CYC  = ns_to_cyc(PRE_GAP_NS, CLK_PERIOD_PS);
    localparam int STB_CYC  = ns_to_cyc(STROBE_NS, CLK_PERIOD_PS);
    localparam int POST_CYC = ns_to_cyc(POST_GAP_NS, CLK_PERIOD_PS);
    localparam int GAP_MAX  = (PRE_CYC > STB_CYC) ? ((PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC)
                                                  : ((STB_CYC > POST_CYC) ? STB_CYC : POST_CYC);
    localparam int GAP_W    = $clog2(GAP_MAX + 1);
    localparam int NW       = $clog2(STREAM_BITS + 1);
    localparam int UTIL_START = STREAM_BITS * 2 * SCLK_HALF_CYC + 1 + PRE_CYC + STB_CYC + POST_CYC;
    localparam int UTIL_END   = UTIL_START + UTIL_BITS * 2 * SCLK_HALF_CYC;
    localparam bit UTIL_FITS  = (UTIL_END < FRAME_CYC);

    typedef struct packed {
        seq_state_e       st;
        logic [GAP_W-1:0] cnt;
        logic             cs_n;
        logic             load_n;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                   tick;
    logic                   ser_start, ser_fin;
    logic [NW-1:0]          ser_bits;
    logic [STREAM_BITS-1:0] ser_word, stream_word, util_word;
    logic                   take;
    logic                   pend_v;
    logic [1:0]             pend_ch;
    logic [15:0]            pend_val;

    dacseq_frame_timer #(.FRAME_CYC(FRAME_CYC)) timer_i (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    dacseq_util_slot slot_i (
        .clk(clk), .rst_n(rst_n), .req(util_req), .req_ch(util_ch), .req_val(util_val),
        .take(take), .pend_v(pend_v), .pend_ch(pend_ch), .pend_val(pend_val)
    );

    dacseq_serializer #(.MAX_BITS(STREAM_BITS), .HALF_CYC(SCLK_HALF_CYC)) ser_i (
        .clk(clk), .rst_n(rst_n), .start(ser_start), .start_bits(ser_bits),
        .start_word(ser_word), .sclk(dac_sclk), .mosi(dac_mosi), .finishing(ser_fin)
    );

    // Address byte first, then channel 0 through 3.
    always_comb begin
        stream_word = '0;
        stream_word[STREAM_BITS-1 -: 8] = WAVE_ADDR;
        for (int c = 0; c < 4; c++)
            stream_word[STREAM_BITS-9-16*c -: 16] = wave_in[16*c +: 16];
    end

    assign util_word = {8'(UTIL_ADDR_BASE + 8'(pend_ch)), pend_val, {(STREAM_BITS-UTIL_BITS){1'b0}}};

    always_comb begin
        ctl_d     = ctl_q;
        ser_start = 1'b0;
        ser_bits  = NW'(STREAM_BITS);
        ser_word  = stream_word;
        take      = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (tick) begin
                    ser_start  = 1'b1;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.st   = ST_STREAM;
                end
            end
            ST_STREAM: begin
                if (ser_fin) begin
                    ctl_d.cs_n = 1'b1;
                    ctl_d.cnt  = '0;
                    ctl_d.st   = ST_GAP_PRE;
                end
            end
            ST_GAP_PRE: begin
                if (ctl_q.cnt == GAP_W'(PRE_CYC - 1)) begin
                    ctl_d.load_n = 1'b0;
                    ctl_d.cnt    = '0;
                    ctl_d.st     = ST_STROBE;
                end else ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ST_STROBE: begin
                if (ctl_q.cnt == GAP_W'(STB_CYC - 1)) begin
                    ctl_d.load_n = 1'b1;
                    ctl_d.cnt    = '0;
                    ctl_d.st     = ST_GAP_POST;
                end else ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ST_GAP_POST: begin
                if (ctl_q.cnt == GAP_W'(POST_CYC - 1)) begin
                    if (UTIL_FITS && pend_v) begin
                        ser_start  = 1'b1;
                        ser_bits   = NW'(UTIL_BITS);
                        ser_word   = util_word;
                        take       = 1'b1;
                        ctl_d.cs_n = 1'b0;
                        ctl_d.st   = ST_UTIL;
                    end else begin
                        ctl_d.st   = ST_IDLE;
                    end
                end else ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            ST_UTIL: begin
                if (ser_fin) begin
                    ctl_d.cs_n = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_IDLE;
            ctl_q.cnt    <= '0;
            ctl_q.cs_n   <= 1'b1;
            ctl_q.load_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign frame_start = tick;
    assign dac_cs_n    = ctl_q.cs_n;
    assign dac_load_n  = ctl_q.load_n;
endmodule

// File: rtl/dacseq_chk.sv
module dacseq_chk
    import dacseq_pkg::*;
#(
    parameter int FRAME_CYC     = 250,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int PRE_GAP_NS    = 20,
    parameter int STROBE_NS     = 20,
    parameter int POST_GAP_NS   = 15
) (
    input logic clk,
    input logic rst_n,
    input logic frame_start,
    input logic dac_sclk,
    input logic dac_mosi,
    input logic dac_cs_n,
    input logic dac_load_n
);
    localparam int PRE_CYC  = ns_to_cyc(PRE_GAP_NS, CLK_PERIOD_PS);
    localparam int STB_CYC  = ns_to_cyc(STROBE_NS, CLK_PERIOD_PS);
    localparam int POST_CYC = ns_to_cyc(POST_GAP_NS, CLK_PERIOD_PS);

    logic [31:0] gap_q;
    logic        seen_q;
    logic [15:0] low_q, cs_run_q, ld_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q    <= '0;
            seen_q   <= 1'b0;
            low_q    <= '0;
            cs_run_q <= '0;
            ld_run_q <= 16'hFFFF;
        end else begin
            gap_q    <= frame_start ? 32'd0 : gap_q + 1;
            seen_q   <= seen_q | frame_start;
            low_q    <= !dac_load_n ? low_q + 1'b1 : 16'd0;
            cs_run_q <= !dac_cs_n ? 16'd0 : ((cs_run_q == 16'hFFFF) ? cs_run_q : cs_run_q + 1'b1);
            ld_run_q <= !dac_load_n ? 16'd0 : ((ld_run_q == 16'hFFFF) ? ld_run_q : ld_run_q + 1'b1);
        end
    end

    assert_frame_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && seen_q) |-> (gap_q == 32'(FRAME_CYC - 1)));

    assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sclk);

    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> $stable(dac_mosi));

    assert_strobe_cs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load_n |-> dac_cs_n);

    assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_load_n) |-> (low_q == 16'(STB_CYC)));

    assert_strobe_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_load_n) |-> (cs_run_q == 16'(PRE_CYC)));

    assert_post_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> (ld_run_q >= 16'(POST_CYC)));
endmodule

bind dacseq_top dacseq_chk #(
    .FRAME_CYC(FRAME_CYC), .CLK_PERIOD_PS(CLK_PERIOD_PS), .PRE_GAP_NS(PRE_GAP_NS),
    .STROBE_NS(STROBE_NS), .POST_GAP_NS(POST_GAP_NS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dac_sclk(dac_sclk),
    .dac_mosi(dac_mosi), .dac_cs_n(dac_cs_n), .dac_load_n(dac_load_n)
);

// File: tb/dacseq_top_tb_top.sv
module dacseq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME = 250;
    localparam int H     = 1;
    localparam int PRE   = 2;
    localparam int STB   = 2;
    localparam int POST  = 2;
    localparam int SEND  = 72 * 2 * H;             // last stream cycle
    localparam int LD0   = SEND + 1 + PRE;         // first strobe cycle
    localparam int U0    = LD0 + STB + POST;       // first auxiliary cycle
    localparam int ULEN  = 24 * 2 * H;
    localparam int NFRAMES = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [63:0] wave_in = '0;
    logic util_req = 1'b0;
    logic [1:0] util_ch = '0;
    logic [15:0] util_val = '0;
    logic frame_start, dac_sclk, dac_mosi, dac_cs_n, dac_load_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .wave_in(wave_in), .util_req(util_req), .util_ch(util_ch),
        .util_val(util_val), .frame_start(frame_start), .dac_sclk(dac_sclk),
        .dac_mosi(dac_mosi), .dac_cs_n(dac_cs_n), .dac_load_n(dac_load_n)
    );

    int total = 0, bad = 0, t = 0;
    logic [71:0] m_word = '0;
    logic [23:0] m_uword = '0;
    bit m_uact = 0, m_pv = 0;
    logic [1:0] m_pch = '0;
    logic [15:0] m_pval = '0;
    int last_low = -1, cs_falls = 0, uwin = 0;
    logic prev_cs = 1'b1;

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s t=%0d actual=%0b expected=%0b", req, what, t, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s t=%0d actual=%0d expected=%0d", req, what, t, act, exp);
        end
    endtask

    task automatic compare(input int k);
        logic e_cs, e_sclk, e_ld, e_mosi;
        string tag;
        e_cs = 1'b1; e_sclk = 1'b0; e_ld = 1'b1; e_mosi = 1'b0;
        tag = "R8";
        if (k >= 1 && k <= SEND) begin
            e_cs = 1'b0; tag = "R2";
            e_sclk = (((k - 1) % (2*H)) >= H);
            e_mosi = m_word[71 - (k - 1) / (2*H)];
        end else if (m_uact && k >= U0 && k < U0 + ULEN) begin
            e_cs = 1'b0; tag = "R6";
            e_sclk = (((k - U0) % (2*H)) >= H);
            e_mosi = m_uword[23 - (k - U0) / (2*H)];
        end else if (k > SEND && k < U0) begin
            tag = "R5";
        end
        if (k >= LD0 && k < LD0 + STB) e_ld = 1'b0;
        chk("R1", "frame_start", frame_start, (k == 0));
        chk((tag == "R6") ? "R7" : tag, "cs_n", dac_cs_n, e_cs);
        chk("R3", "sclk", dac_sclk, e_sclk);
        chk("R4", "load_n", dac_load_n, e_ld);
        if (!e_cs) chk(tag, "mosi", dac_mosi, e_mosi);
    endtask

    task automatic drive(input int f, input int k);
        util_req = 1'b0;
        wave_in  = {$urandom, $urandom};   // changes every cycle: only the tick value counts (R1)
        if (f == 1 && k == 20)  begin util_req = 1'b1; util_ch = 2'd0; util_val = 16'hA001; end
        if (f == 2 && k == 10)  begin util_req = 1'b1; util_ch = 2'd1; util_val = 16'hB002; end
        if (f == 2 && k == 100) begin util_req = 1'b1; util_ch = 2'd3; util_val = 16'hB003; end // R7 overwrite
        if (f == 3 && k == 170) begin util_req = 1'b1; util_ch = 2'd2; util_val = 16'hC004; end
        if (f == 5 && k == U0-1) begin util_req = 1'b1; util_ch = 2'd1; util_val = 16'hD005; end
        if (f == 6 && k == U0-1) begin util_req = 1'b1; util_ch = 2'd3; util_val = 16'hE006; end
    endtask

    task automatic model_step(input int k);
        bit launch;
        if (k == 0) begin
            m_word = {8'h14, wave_in[15:0], wave_in[31:16], wave_in[47:32], wave_in[63:48]};
            m_uact = 0;
        end
        launch = (k == U0 - 1) && m_pv;
        if (launch) begin
            m_uact  = 1;
            m_uword = {8'h18 + {6'd0, m_pch}, m_pval};
        end
        if (util_req) begin m_pv = 1; m_pch = util_ch; m_pval = util_val; end
        else if (launch) m_pv = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2", "reset cs_n", dac_cs_n, 1'b1);
        chk("R4", "reset load_n", dac_load_n, 1'b1);
        chk("R3", "reset sclk", dac_sclk, 1'b0);
        for (int i = 0; i < NFRAMES * FRAME; i++) begin
            int k, f;
            t = i; k = i % FRAME; f = i / FRAME;
            compare(k);
            if (!dac_cs_n) last_low = k;
            if (prev_cs && !dac_cs_n) cs_falls++;
            prev_cs = dac_cs_n;
            if (k == FRAME - 1) begin
                total++;
                if (last_low + 1 > 2 * 125 || last_low >= FRAME - 1) begin
                    bad++;
                    $display("FAIL R9 frame budget t=%0d actual=%0d expected<=%0d", t, last_low + 1, 2 * 125);
                end
                chk_int("R7", "windows per frame", cs_falls, uwin + 1);
                last_low = -1; cs_falls = 0;
            end
            drive(f, k);
            model_step(k);
            uwin = m_uact ? 1 : 0;
            @(negedge clk);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired t=%0d actual=running expected=done", t);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule